// File: doc/BRIEF.md
# Two-Port Root Hub Port State Block

This block holds the software-visible state of the downstream ports of a root hub inside a host controller. Each port has a status byte (connected, enabled, suspended, and a reset bit that always reads 0), a change byte that latches events, and a power bit. Software changes these through byte writes on a simple register port. The bits of a status write are commands, not stored data. A device-attach register stands in for a device being plugged in. Global set-power and clear-power commands act on the ports according to the power switching mode and a per-port power mask. Line signalling, resume timing and packet traffic are not modelled. A port reset completes in the cycle of the write.

Each port's link is a three-state machine:
- `ST_DETACHED` moves to `ST_ATTACHED` on *attach*.
- `ST_ATTACHED` moves to `ST_ACTIVE` on *enable*.
- `ST_ACTIVE` moves back to `ST_ATTACHED` on *disable*.
- Any state moves to `ST_DETACHED` on *power-off*.

Suspend and power are flags held beside the machine. Every register write takes effect at the next clock edge. Reads are combinational from the held state.

Register offsets (byte addresses): status bytes 0x54 (port 1) and 0x58 (port 2). Change bytes are two above each status byte (0x56, 0x5A). Power bytes are one above each status byte (0x55, 0x59, bit 0). The switching mode register is 0x49, the attach register 0x4C, the power mask 0x4E, global clear-power 0x50 bit 0, and global set-power 0x52 bit 0.

Top module: `usb_root_hub_ports`

## Requirements
- R1: After reset every port is unpowered and detached. All status, change and power bytes read 0, and 0x49, 0x4C and 0x4E read 0.
- R2: A write to 0x4C stores bits 0x06. A 0 written in bit 1 (port 1) or bit 2 (port 2) sets that port's connected bit (status bit 0). It also sets change bit 0, but only if the port was not already connected.
- R3: On a connected port, a status write with bit 1 sets enabled (status bit 1), and bit 0 clears it. When both are written, disable wins.
- R4: On an unconnected port, a status write with bit 0, 1 or 4 sets change bit 0 and leaves the port's status unchanged.
- R5: On a connected port, a status write with bit 4 sets change bit 4, and status bit 4 reads back 0.
- R6: A status write with bit 2 sets suspended (status bit 2), and bit 3 clears it. Set wins when both are written. A 1-to-0 change of suspended sets change bit 2.
- R7: A write to a change byte clears each of its low 5 bits that is written 1.
- R8: A write to 0x49 keeps bits 0x1B. If bit 1 of the written value is set, both ports are powered.
- R9: In mode 0 (0x49 bits [1:0] = 00), global clear-power removes power from both ports, and global set-power powers both. Removing power clears the power bit, clears mask 0x17 in the status and change bytes, and detaches the port.
- R10: In mode 1, global set-power and clear-power act only on ports whose mask bit is 0. 0x4E keeps 0x06; bit 1 is port 1 and bit 2 is port 2.
- R11: In modes 2 and 3, global set-power and clear-power have no effect.
- R12: The port_connected, port_enabled, port_suspended and port_powered outputs (bit 0 = port 1) follow the status and power bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte value |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte value (combinational) |
| port_connected | output | NUM_PORTS | Per-port connected |
| port_enabled | output | NUM_PORTS | Per-port enabled |
| port_suspended | output | NUM_PORTS | Per-port suspended |
| port_powered | output | NUM_PORTS | Per-port powered |

## Verification
A port machine left in the wrong state shows up at the next read of the status byte, and on the per-port outputs one cycle after the write that caused it. A missing or spurious event appears in the change byte at that same read. Because change bits stay set until software clears them, an event raised wrongly several writes earlier is still visible later. A power command that reaches the wrong port shows both on that port's power byte and on its status and change bytes, which are cleared at the same edge.

// File: rtl/usb_rh_pkg.sv
package usb_rh_pkg;

    typedef enum logic [1:0] {
        ST_DETACHED = 2'd0,
        ST_ATTACHED = 2'd1,
        ST_ACTIVE   = 2'd2
    } link_state_e;

    localparam logic [7:0] A_PSW_MODE  = 8'h49;
    localparam logic [7:0] A_ATTACH    = 8'h4C;
    localparam logic [7:0] A_PWR_MASK  = 8'h4E;
    localparam logic [7:0] A_GLB_CLR   = 8'h50;
    localparam logic [7:0] A_GLB_SET   = 8'h52;
    localparam logic [7:0] A_PORT_BASE = 8'h54;
    localparam int         PORT_STRIDE = 4;
    localparam int         OFS_POWER   = 1;
    localparam int         OFS_CHANGE  = 2;

    localparam logic [7:0] PSW_KEEP    = 8'h1B;
    localparam logic [1:0] PSW_GANGED  = 2'b00;
    localparam logic [1:0] PSW_PERPORT = 2'b01;
    localparam logic [4:0] PWR_OFF_CLR = 5'h17;

endpackage

// File: rtl/rh_port.sv
module rh_port
    import usb_rh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [4:0] cmd_data,
    input  logic       chg_we,
    input  logic [4:0] chg_data,
    input  logic       attach_req,
    input  logic       pwr_on,
    input  logic       pwr_off,
    output logic       connected,
    output logic       enabled,
    output logic       suspended,
    output logic       powered,
    output logic [7:0] status_byte,
    output logic [7:0] change_byte,
    output logic [7:0] power_byte
);

    link_state_e st_q, st_d;
    logic        susp_q, susp_d;
    logic        pwr_q, pwr_d;
    logic [4:0]  chg_q, chg_d;
    logic        conn_now;

    assign conn_now = (st_q != ST_DETACHED);

    always_comb begin
        st_d   = st_q;
        susp_d = susp_q;
        pwr_d  = pwr_q;
        chg_d  = chg_q;
        if (pwr_off) begin
            pwr_d  = 1'b0;
            st_d   = ST_DETACHED;
            susp_d = 1'b0;
            chg_d  = chg_q & ~PWR_OFF_CLR;
        end else if (pwr_on) begin
            pwr_d = 1'b1;
        end
        if (attach_req) begin
            if (!conn_now) begin
                chg_d[0] = 1'b1;
                st_d     = ST_ATTACHED;
            end
        end
        if (chg_we) begin
            chg_d = chg_q & ~chg_data;
        end
        if (cmd_we) begin
            if (cmd_data[4]) begin
                if (conn_now) chg_d[4] = 1'b1;
                else          chg_d[0] = 1'b1;
            end
            if (cmd_data[3]) susp_d = 1'b0;
            if (cmd_data[2]) susp_d = 1'b1;
            unique case (st_q)
                ST_DETACHED: begin
                    if (cmd_data[1] || cmd_data[0]) chg_d[0] = 1'b1;
                end
                ST_ATTACHED: begin
                    if (cmd_data[1] && !cmd_data[0]) st_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (cmd_data[0]) st_d = ST_ATTACHED;
                end
                default: st_d = ST_DETACHED;
            endcase
            if (susp_q && !susp_d) chg_d[2] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_DETACHED;
            susp_q <= 1'b0;
            pwr_q  <= 1'b0;
            chg_q  <= '0;
        end else begin
            st_q   <= st_d;
            susp_q <= susp_d;
            pwr_q  <= pwr_d;
            chg_q  <= chg_d;
        end
    end

    always_comb begin
        connected   = (st_q != ST_DETACHED);
        enabled     = (st_q == ST_ACTIVE);
        suspended   = susp_q;
        powered     = pwr_q;
        status_byte = {5'b0, susp_q, (st_q == ST_ACTIVE), (st_q != ST_DETACHED)};
        change_byte = {3'b0, chg_q};
        power_byte  = {7'b0, pwr_q};
    end

    // R3: disable on a connected port always leaves it not enabled
    p_disable_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && connected && cmd_data[0]) |=> !enabled);

    // R4: commands to a detached port raise connect change only
    p_unconn_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !connected && (cmd_data[0] || cmd_data[1] || cmd_data[4]))
        |=> (change_byte[0] && !connected && !enabled));

    // R5: reset on a connected port completes at once
    p_reset_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && connected && cmd_data[4]) |=> (change_byte[4] && !status_byte[4]));

    // R6: leaving suspend is reported
    p_resume_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && suspended && cmd_data[3] && !cmd_data[2])
        |=> (change_byte[2] && !suspended));

    // R7: written ones clear change bits
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_we |=> ((change_byte[4:0] & $past(chg_data)) == 5'b0));

    // R9: power removal detaches and clears the port
    p_pwr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> (!powered && !connected && !suspended
                     && ((change_byte[4:0] & PWR_OFF_CLR) == 5'b0)));

    // R12: enabled never appears without a connection
    p_enable_conn_r12: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> connected);

endmodule

// File: rtl/rh_power_ctl.sv
module rh_power_ctl
    import usb_rh_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           mode_byte,
    output logic [7:0]           attach_byte,
    output logic [7:0]           mask_byte,
    output logic [NUM_PORTS-1:0] attach_req,
    output logic [NUM_PORTS-1:0] pwr_on,
    output logic [NUM_PORTS-1:0] pwr_off
);

    localparam logic [7:0] PORT_FIELD = 8'(((1 << NUM_PORTS) - 1) << 1);

    logic [7:0] mode_q, attach_q, mask_q;
    logic       wr_mode, wr_attach, wr_mask, glb_set, glb_clr;

    assign wr_mode   = wr_en && (wr_addr == A_PSW_MODE);
    assign wr_attach = wr_en && (wr_addr == A_ATTACH);
    assign wr_mask   = wr_en && (wr_addr == A_PWR_MASK);
    assign glb_clr   = wr_en && (wr_addr == A_GLB_CLR) && wr_data[0];
    assign glb_set   = wr_en && (wr_addr == A_GLB_SET) && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            attach_q <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_mode)   mode_q   <= wr_data & PSW_KEEP;
            if (wr_attach) attach_q <= wr_data & PORT_FIELD;
            if (wr_mask)   mask_q   <= wr_data & PORT_FIELD;
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
        logic sel;
        always_comb begin
            unique case (mode_q[1:0])
                PSW_GANGED:  sel = 1'b1;
                PSW_PERPORT: sel = !mask_q[i+1];
                default:     sel = 1'b0;
            endcase
        end
        assign attach_req[i] = wr_attach && !wr_data[i+1];
        assign pwr_on[i]     = (wr_mode && wr_data[1]) || (glb_set && sel);
        assign pwr_off[i]    = glb_clr && sel;
    end

    assign mode_byte   = mode_q;
    assign attach_byte = attach_q;
    assign mask_byte   = mask_q;

    // R11: modes 2 and 3 never switch power globally
    p_no_glb_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && (glb_set || glb_clr) && !wr_mode)
        |-> ((pwr_on == '0) && (pwr_off == '0)));

    // R10: a masked port in mode 1 ignores the global clear
    p_masked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == PSW_PERPORT && glb_clr && mask_q[1]) |-> !pwr_off[0]);

endmodule

// File: rtl/usb_root_hub_ports.sv
module usb_root_hub_ports
    import usb_rh_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [7:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic [NUM_PORTS-1:0] port_connected,
    output logic [NUM_PORTS-1:0] port_enabled,
    output logic [NUM_PORTS-1:0] port_suspended,
    output logic [NUM_PORTS-1:0] port_powered
);

    logic [7:0]           mode_byte, attach_byte, mask_byte;
    logic [NUM_PORTS-1:0] attach_req, pwr_on, pwr_off;
    logic [7:0]           st_b  [NUM_PORTS];
    logic [7:0]           chg_b [NUM_PORTS];
    logic [7:0]           pwr_b [NUM_PORTS];

    rh_power_ctl #(.NUM_PORTS(NUM_PORTS)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mode_byte   (mode_byte),
        .attach_byte (attach_byte),
        .mask_byte   (mask_byte),
        .attach_req  (attach_req),
        .pwr_on      (pwr_on),
        .pwr_off     (pwr_off)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam logic [7:0] A_ST  = 8'(A_PORT_BASE + PORT_STRIDE * i);
        localparam logic [7:0] A_CHG = 8'(A_ST + OFS_CHANGE);
        rh_port u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we      (wr_en && (wr_addr == A_ST)),
            .cmd_data    (wr_data[4:0]),
            .chg_we      (wr_en && (wr_addr == A_CHG)),
            .chg_data    (wr_data[4:0]),
            .attach_req  (attach_req[i]),
            .pwr_on      (pwr_on[i]),
            .pwr_off     (pwr_off[i]),
            .connected   (port_connected[i]),
            .enabled     (port_enabled[i]),
            .suspended   (port_suspended[i]),
            .powered     (port_powered[i]),
            .status_byte (st_b[i]),
            .change_byte (chg_b[i]),
            .power_byte  (pwr_b[i])
        );
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == A_PSW_MODE) rd_data = mode_byte;
        if (rd_addr == A_ATTACH)   rd_data = attach_byte;
        if (rd_addr == A_PWR_MASK) rd_data = mask_byte;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_addr == 8'(A_PORT_BASE + PORT_STRIDE * i))
                rd_data = st_b[i];
            if (rd_addr == 8'(A_PORT_BASE + PORT_STRIDE * i + OFS_POWER))
                rd_data = pwr_b[i];
            if (rd_addr == 8'(A_PORT_BASE + PORT_STRIDE * i + OFS_CHANGE))
                rd_data = chg_b[i];
        end
    end

    // R8: a mode write with bit 1 powers every port
    p_mode_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PSW_MODE && wr_data[1]) |=> (port_powered == '1));

    // R2: attach through a zero bit connects the port
    p_attach_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ATTACH && !wr_data[1]) |=> port_connected[0]);

endmodule

// File: tb/test_usb_root_hub_ports.sv
module test_usb_root_hub_ports;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] port_connected, port_enabled, port_suspended, port_powered;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    usb_root_hub_ports i_usb_root_hub_ports (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .port_connected(port_connected), .port_enabled(port_enabled),
        .port_suspended(port_suspended), .port_powered(port_powered)
    );

    // {we, waddr, wdata, raddr, expected}
    localparam int NV = 41;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h00},  // R1
        {1'b0, 8'h00, 8'h00, 8'h56, 8'h00},  // R1
        {1'b0, 8'h00, 8'h00, 8'h49, 8'h00},  // R1
        {1'b1, 8'h54, 8'h02, 8'h56, 8'h01},  // R4
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h00},  // R4
        {1'b1, 8'h56, 8'h01, 8'h56, 8'h00},  // R7
        {1'b1, 8'h4C, 8'h04, 8'h54, 8'h01},  // R2
        {1'b0, 8'h00, 8'h00, 8'h56, 8'h01},  // R2
        {1'b0, 8'h00, 8'h00, 8'h58, 8'h00},  // R2
        {1'b0, 8'h00, 8'h00, 8'h4C, 8'h04},  // R2
        {1'b1, 8'h56, 8'h1F, 8'h56, 8'h00},  // R7
        {1'b1, 8'h4C, 8'h00, 8'h56, 8'h00},  // R2
        {1'b0, 8'h00, 8'h00, 8'h5A, 8'h01},  // R2
        {1'b1, 8'h54, 8'h02, 8'h54, 8'h03},  // R3
        {1'b1, 8'h54, 8'h03, 8'h54, 8'h01},  // R3
        {1'b1, 8'h54, 8'h10, 8'h56, 8'h10},  // R5
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h01},  // R5
        {1'b1, 8'h54, 8'h04, 8'h54, 8'h05},  // R6
        {1'b1, 8'h54, 8'h0C, 8'h54, 8'h05},  // R6
        {1'b0, 8'h00, 8'h00, 8'h56, 8'h10},  // R6
        {1'b1, 8'h54, 8'h08, 8'h56, 8'h14},  // R6
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h01},  // R6
        {1'b1, 8'h49, 8'hFF, 8'h49, 8'h1B},  // R8
        {1'b0, 8'h00, 8'h00, 8'h55, 8'h01},  // R8
        {1'b0, 8'h00, 8'h00, 8'h59, 8'h01},  // R8
        {1'b1, 8'h50, 8'h01, 8'h55, 8'h01},  // R11
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h01},  // R11
        {1'b1, 8'h49, 8'h01, 8'h49, 8'h01},  // R8
        {1'b1, 8'h4E, 8'hFF, 8'h4E, 8'h06},  // R10
        {1'b1, 8'h4E, 8'h04, 8'h4E, 8'h04},  // R10
        {1'b1, 8'h50, 8'h01, 8'h55, 8'h00},  // R10
        {1'b0, 8'h00, 8'h00, 8'h54, 8'h00},  // R9
        {1'b0, 8'h00, 8'h00, 8'h56, 8'h00},  // R9
        {1'b0, 8'h00, 8'h00, 8'h59, 8'h01},  // R10
        {1'b0, 8'h00, 8'h00, 8'h5A, 8'h01},  // R10
        {1'b1, 8'h52, 8'h01, 8'h55, 8'h01},  // R10
        {1'b1, 8'h49, 8'h00, 8'h49, 8'h00},  // R8
        {1'b1, 8'h50, 8'h01, 8'h59, 8'h00},  // R9
        {1'b0, 8'h00, 8'h00, 8'h58, 8'h00},  // R9
        {1'b0, 8'h00, 8'h00, 8'h5A, 8'h00},  // R9
        {1'b1, 8'h52, 8'h01, 8'h59, 8'h01}   // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 outputs", {port_connected, port_enabled, port_suspended, port_powered}, 8'h00);
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
            check($sformatf("vector %0d R-tagged", k), rd_data, VEC[k][7:0]);
        end
        // R9: both powered, both detached after the mode 0 clear/set pair
        check("R9 pwr", {6'b0, port_powered}, 8'h03);
        check("R9 conn", {6'b0, port_connected}, 8'h00);
        // R12: outputs mirror state
        step(1'b1, 8'h4C, 8'h00, 8'h58);
        step(1'b1, 8'h58, 8'h02, 8'h58);
        check("R12 status", rd_data, 8'h03);
        check("R12 enabled", {6'b0, port_enabled}, 8'h02);
        check("R12 connected", {6'b0, port_connected}, 8'h03);
        step(1'b1, 8'h54, 8'h04, 8'h54);
        check("R12 suspended", {6'b0, port_suspended}, 8'h01);
        // R4: reset command to a detached port after power loss
        step(1'b1, 8'h50, 8'h01, 8'h54);
        step(1'b1, 8'h54, 8'h10, 8'h56);
        check("R4 reset unconnected", rd_data, 8'h01);
        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; rd_addr = 8'h49;
        #1;
        check("R1 mode after reset", rd_data, 8'h00);
        check("R1 outputs after reset",
              {port_connected, port_enabled, port_suspended, port_powered}, 8'h00);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule